// File: doc/BRIEF.md
# RMII 10 Mbps Frame Receiver

This block receives Ethernet frames from an RMII PHY running at 10 Mbps. It is clocked by the 50 MHz RMII reference clock. It samples the two receive data pins and the carrier/data-valid pin once per dibit period. It waits for a clean carrier rising edge and then hunts through the preamble for the start-of-frame dibit. It then packs the dibits into bytes and writes each byte into one of two alternating frame banks.

The write port carries the address and data of each byte, and the bank that receives it. When the carrier is found low at a sample point, the frame closes. The block then emits a one-cycle completion pulse carrying the bank, the byte count and two verdicts: whether the trailing FCS matches, and whether the frame is acceptable. Reception then continues in the other bank straight away. A consumer can therefore drain one bank while the next frame lands in the other.

Top module: `rmii_rx_frame`

## Requirements
- R1: Out of reset no write and no completion pulse is issued, and the write bank is 0.
- R2: A frame is recognised only after the carrier/data-valid input has been seen low and then high. A frame whose carrier is already high when reset releases produces no write and no completion.
- R3: After the carrier rises, the block waits for a sample with RXD0 high, then a sample with RXD1 low, then a sample with RXD1 high (the `11` start dibit). Data capture begins with the next dibit, and dibits before it (including `00` and `01`) are never written.
- R4: Dibits are sampled every DIV reference clocks, at the clock midway through their hold time, with the phase set by the carrier rising edge. The first dibit of a byte lands in bits [1:0] and the fourth in bits [7:6].
- R5: The carrier is examined at every dibit sample. The first sample with carrier low ends the frame and is not data. Whole bytes only are counted, and a trailing partial byte is dropped.
- R6: Each frame end raises `done_o` for exactly one clock, reporting the bank the frame was written to. The write bank then toggles, so successive frames alternate between banks 0 and 1.
- R7: Byte k of a frame is written to address k only while k < MAX_LEN. The reported length saturates at MAX_LEN+1. A frame is accepted only when its length lies in MIN_LEN..MAX_LEN inclusive.
- R8: The FCS is good when the reflected CRC-32 (polynomial 0xEDB88320, register preset to all ones, result complemented) of the first length−4 bytes equals the last four bytes, taken least significant byte first. Acceptance also requires a good FCS.
- R9: A frame whose carrier rises one dibit period after the previous frame's closing sample is received in full into the other bank.
- R10: If the carrier drops during the preamble hunt, the attempt is abandoned with no completion and no bank change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 50 MHz RMII reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 2 | Receive dibit from the PHY, bit 0 first on the wire |
| crs_dv_i | input | 1 | Carrier sense / data valid from the PHY |
| wr_en_o | output | 1 | Byte write strobe |
| wr_bank_o | output | 1 | Bank receiving the current frame |
| wr_addr_o | output | $clog2(MAX_LEN) | Byte offset within the bank |
| wr_data_o | output | 8 | Received byte |
| done_o | output | 1 | One-cycle frame completion pulse |
| done_bank_o | output | 1 | Bank holding the completed frame |
| done_len_o | output | $clog2(MAX_LEN+2) | Whole bytes received, saturated at MAX_LEN+1 |
| done_accept_o | output | 1 | Length within limits and FCS good |
| done_fcs_ok_o | output | 1 | FCS matches the computed CRC |

## Verification
The bench builds the block with DIV=10, MIN_LEN=20 and MAX_LEN=96. A frame at the upper limit, or one past it, then costs only a few thousand clocks. This brings the length-limit, saturation and write-suppression paths within reach, alongside short, bad-FCS, partial-byte, glitched-edge, aborted-preamble and back-to-back frames. The scoreboard predicts every byte write and every completion, including the bank each one should carry, from the requirement rules alone.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARMED,
    S_PRE_D0,
    S_PRE_D1LO,
    S_PRE_SFD,
    S_DATA
  } rx_state_e;

  localparam logic [31:0] CRC_POLY    = 32'hEDB8_8320;
  localparam logic [31:0] CRC_PRESET  = 32'hFFFF_FFFF;
  // register value after a correct frame plus its FCS has been folded in
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rmii_rx_sampler.sv
module rmii_rx_sampler #(
  parameter int DIV = 10,
  localparam int CW = $clog2(DIV),
  localparam int CENTER = DIV / 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rxd_i,
  input  logic       crs_dv_i,
  output logic [1:0] rxd_o,
  output logic       crs_o,
  output logic       rise_o,
  output logic       tick_o
);

  logic [1:0]    rxd_q;
  logic          crs_q, crs_d;
  logic [CW-1:0] cnt_q;

  // carrier regs reset high so a carrier already up at reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_q <= '0;
      crs_q <= 1'b1;
      crs_d <= 1'b1;
    end else begin
      rxd_q <= rxd_i;
      crs_q <= crs_dv_i;
      crs_d <= crs_q;
    end
  end

  assign rise_o = crs_q & ~crs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (rise_o)                  cnt_q <= CW'(1);
    else if (cnt_q == CW'(DIV - 1))   cnt_q <= '0;
    else                              cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = (cnt_q == CW'(CENTER));
  assign rxd_o  = rxd_q;
  assign crs_o  = crs_q;

  a_r4_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  a_r4_rise_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !tick_o);

endmodule

// File: rtl/rmii_rx_fcs.sv
module rmii_rx_fcs
  import rmii_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       vld_i,
  input  logic [7:0] byte_i,
  output logic       ok_o
);

  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_PRESET;
    else if (clear_i) crc_q <= CRC_PRESET;
    else if (vld_i)   crc_q <= crc_step(crc_q, byte_i);
  end

  assign ok_o = (crc_q == CRC_RESIDUE);

  a_r8_clear_not_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !ok_o);

endmodule

// File: rtl/rmii_rx_framer.sv
module rmii_rx_framer
  import rmii_rx_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1522,
  localparam int AW = $clog2(MAX_LEN),
  localparam int LW = $clog2(MAX_LEN + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    rxd_i,
  input  logic          crs_i,
  input  logic          rise_i,
  input  logic          tick_i,
  input  logic          fcs_ok_i,
  output logic          start_o,
  output logic          byte_vld_o,
  output logic          wr_en_o,
  output logic          wr_bank_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          done_o,
  output logic          done_bank_o,
  output logic [LW-1:0] done_len_o,
  output logic          done_accept_o,
  output logic          done_fcs_ok_o
);

  localparam logic [LW-1:0] LEN_MIN = LW'(MIN_LEN);
  localparam logic [LW-1:0] LEN_MAX = LW'(MAX_LEN);
  localparam logic [LW-1:0] LEN_SAT = LW'(MAX_LEN + 1);

  rx_state_e     state_q;
  logic [7:0]    sr_q, byte_q;
  logic [1:0]    dcnt_q;
  logic [LW-1:0] bcnt_q;
  logic          bank_q;
  logic [7:0]    sr_nxt;
  logic          len_ok;

  assign sr_nxt = {rxd_i, sr_q[7:2]};
  assign len_ok = (bcnt_q >= LEN_MIN) && (bcnt_q <= LEN_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= S_IDLE;
      sr_q          <= '0;
      byte_q        <= '0;
      dcnt_q        <= '0;
      bcnt_q        <= '0;
      bank_q        <= 1'b0;
      start_o       <= 1'b0;
      byte_vld_o    <= 1'b0;
      wr_en_o       <= 1'b0;
      wr_addr_o     <= '0;
      done_o        <= 1'b0;
      done_bank_o   <= 1'b0;
      done_len_o    <= '0;
      done_accept_o <= 1'b0;
      done_fcs_ok_o <= 1'b0;
    end else begin
      start_o    <= 1'b0;
      byte_vld_o <= 1'b0;
      wr_en_o    <= 1'b0;
      done_o     <= 1'b0;
      unique case (state_q)
        S_IDLE:  if (!crs_i) state_q <= S_ARMED;
        S_ARMED: if (rise_i) state_q <= S_PRE_D0;
        S_PRE_D0: if (tick_i) begin
          if (!crs_i)        state_q <= S_ARMED;
          else if (rxd_i[0]) state_q <= S_PRE_D1LO;
        end
        S_PRE_D1LO: if (tick_i) begin
          if (!crs_i)         state_q <= S_ARMED;
          else if (!rxd_i[1]) state_q <= S_PRE_SFD;
        end
        S_PRE_SFD: if (tick_i) begin
          if (!crs_i) state_q <= S_ARMED;
          else if (rxd_i[1]) begin
            state_q <= S_DATA;
            dcnt_q  <= '0;
            bcnt_q  <= '0;
            start_o <= 1'b1;
          end
        end
        S_DATA: if (tick_i) begin
          if (!crs_i) begin
            // closing sample: partial byte in sr_q is dropped
            done_o        <= 1'b1;
            done_bank_o   <= bank_q;
            done_len_o    <= bcnt_q;
            done_accept_o <= len_ok & fcs_ok_i;
            done_fcs_ok_o <= fcs_ok_i;
            bank_q        <= ~bank_q;
            state_q       <= S_ARMED;
          end else begin
            sr_q   <= sr_nxt;
            dcnt_q <= dcnt_q + 2'd1;
            if (dcnt_q == 2'd3) begin
              byte_q     <= sr_nxt;
              byte_vld_o <= 1'b1;
              if (bcnt_q < LEN_MAX) begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= AW'(bcnt_q);
              end
              if (bcnt_q != LEN_SAT) bcnt_q <= bcnt_q + LW'(1);
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign wr_bank_o = bank_q;
  assign wr_data_o = byte_q;

  a_r7_addr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o < AW'(MAX_LEN)));

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_bank_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (wr_bank_o != done_bank_o));

  a_r7_accept_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_accept_o) |-> (done_len_o >= LEN_MIN && done_len_o <= LEN_MAX));

  a_r5_no_write_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_en_o);

  a_r4_write_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

endmodule

// File: rtl/rmii_rx_frame.sv
module rmii_rx_frame #(
  parameter int DIV = 10,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1522,
  localparam int AW = $clog2(MAX_LEN),
  localparam int LW = $clog2(MAX_LEN + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    rxd_i,
  input  logic          crs_dv_i,
  output logic          wr_en_o,
  output logic          wr_bank_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          done_o,
  output logic          done_bank_o,
  output logic [LW-1:0] done_len_o,
  output logic          done_accept_o,
  output logic          done_fcs_ok_o
);

  logic [1:0] s_rxd;
  logic       s_crs, s_rise, s_tick;
  logic       f_start, f_vld, fcs_ok;

  rmii_rx_sampler #(.DIV(DIV)) u_smp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rxd_i    (rxd_i),
    .crs_dv_i (crs_dv_i),
    .rxd_o    (s_rxd),
    .crs_o    (s_crs),
    .rise_o   (s_rise),
    .tick_o   (s_tick)
  );

  rmii_rx_framer #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_frm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rxd_i         (s_rxd),
    .crs_i         (s_crs),
    .rise_i        (s_rise),
    .tick_i        (s_tick),
    .fcs_ok_i      (fcs_ok),
    .start_o       (f_start),
    .byte_vld_o    (f_vld),
    .wr_en_o       (wr_en_o),
    .wr_bank_o     (wr_bank_o),
    .wr_addr_o     (wr_addr_o),
    .wr_data_o     (wr_data_o),
    .done_o        (done_o),
    .done_bank_o   (done_bank_o),
    .done_len_o    (done_len_o),
    .done_accept_o (done_accept_o),
    .done_fcs_ok_o (done_fcs_ok_o)
  );

  rmii_rx_fcs u_fcs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (f_start),
    .vld_i   (f_vld),
    .byte_i  (wr_data_o),
    .ok_o    (fcs_ok)
  );

endmodule

// File: tb/sim_rmii_rx_frame.sv
module sim_rmii_rx_frame;

  localparam int DIV = 10;
  localparam int MIN_LEN = 20;
  localparam int MAX_LEN = 96;
  localparam int AW = $clog2(MAX_LEN);
  localparam int LW = $clog2(MAX_LEN + 2);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    rxd_i = 2'b00;
  logic          crs_dv_i = 1'b1;
  logic          wr_en_o, wr_bank_o, done_o, done_bank_o, done_accept_o, done_fcs_ok_o;
  logic [AW-1:0] wr_addr_o;
  logic [7:0]    wr_data_o;
  logic [LW-1:0] done_len_o;

  always #5 clk_i = ~clk_i;

  rmii_rx_frame #(.DIV(DIV), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u0 (
    .clk_i, .rst_ni, .rxd_i, .crs_dv_i, .wr_en_o, .wr_bank_o, .wr_addr_o,
    .wr_data_o, .done_o, .done_bank_o, .done_len_o, .done_accept_o, .done_fcs_ok_o
  );

  typedef struct {bit bank; int addr; int data; string tag;} wr_exp_t;
  typedef struct {bit bank; int len; bit acc; bit fcs; string tag;} dn_exp_t;

  wr_exp_t    wq[$];
  dn_exp_t    dq[$];
  logic [7:0] frm[$];
  int         n_chk = 0, n_fail = 0;
  bit         exp_bank = 1'b0;
  bit         finished = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_ref(int cnt);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < cnt; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ frm[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return ~c;
  endfunction

  task automatic build(int n, int seed, bit good);
    logic [31:0] c;
    frm.delete();
    for (int i = 0; i < n - 4; i++) frm.push_back(8'((seed * 37 + i * 13 + (i >> 3)) & 255));
    c = crc_ref(n - 4);
    if (!good) c = c ^ 32'h1;
    for (int k = 0; k < 4; k++) frm.push_back(c[8*k +: 8]);
  endtask

  task automatic expect_frame(string tag);
    int n = frm.size();
    dn_exp_t d;
    logic [31:0] got;
    for (int i = 0; i < n && i < MAX_LEN; i++) begin
      wr_exp_t w;
      w.bank = exp_bank; w.addr = i; w.data = int'(frm[i]); w.tag = tag;
      wq.push_back(w);
    end
    got = {frm[n-1], frm[n-2], frm[n-3], frm[n-4]};
    d.bank = exp_bank;
    d.len  = (n > MAX_LEN) ? MAX_LEN + 1 : n;
    d.fcs  = (crc_ref(n - 4) == got);
    d.acc  = d.fcs && n >= MIN_LEN && n <= MAX_LEN;
    d.tag  = tag;
    dq.push_back(d);
    exp_bank = ~exp_bank;
  endtask

  task automatic dibit(logic [1:0] d, logic c, bit g);
    crs_dv_i = c;
    if (g) begin
      rxd_i = ~d; repeat (2) @(negedge clk_i);
      rxd_i = d;  repeat (6) @(negedge clk_i);
      rxd_i = ~d; repeat (2) @(negedge clk_i);
    end else begin
      rxd_i = d;  repeat (10) @(negedge clk_i);
    end
  endtask

  task automatic send(int lead, int npre, int extra, bit g, int gap_d);
    for (int i = 0; i < lead; i++) dibit(2'b00, 1'b1, g);
    for (int i = 0; i < npre; i++) dibit(2'b01, 1'b1, g);
    dibit(2'b11, 1'b1, g);
    foreach (frm[i]) for (int k = 0; k < 4; k++) dibit(frm[i][2*k +: 2], 1'b1, g);
    for (int i = 0; i < extra; i++) dibit(2'b10, 1'b1, g);
    for (int i = 0; i < gap_d; i++) dibit(2'b00, 1'b0, 1'b0);
  endtask

  task automatic drain(string tag);
    repeat (20) @(negedge clk_i);
    chk(wq.size() == 0, tag, "writes outstanding", wq.size(), 0);
    chk(dq.size() == 0, tag, "completions outstanding", dq.size(), 0);
  endtask

  // monitor: compare each design event against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (wr_en_o) begin
        if (wq.size() == 0) chk(1'b0, "R2", "unexpected write", 1, 0);
        else begin
          wr_exp_t e;
          e = wq.pop_front();
          chk(int'(wr_addr_o) == e.addr, e.tag, "write addr", int'(wr_addr_o), e.addr);
          chk(int'(wr_data_o) == e.data, e.tag, "write data (R4 dibit order)", int'(wr_data_o), e.data);
          chk(wr_bank_o == e.bank, "R6", "write bank", int'(wr_bank_o), int'(e.bank));
        end
      end
      if (done_o) begin
        if (dq.size() == 0) chk(1'b0, "R10", "unexpected completion", 1, 0);
        else begin
          dn_exp_t e;
          e = dq.pop_front();
          chk(done_bank_o == e.bank, "R6", "done bank", int'(done_bank_o), int'(e.bank));
          chk(int'(done_len_o) == e.len, "R5", "done length", int'(done_len_o), e.len);
          chk(done_fcs_ok_o == e.fcs, "R8", "fcs verdict", int'(done_fcs_ok_o), int'(e.fcs));
          chk(done_accept_o == e.acc, e.tag, "accept verdict", int'(done_accept_o), int'(e.acc));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk_i);
    // R1: reset state
    chk(wr_en_o == 1'b0, "R1", "wr_en in reset", int'(wr_en_o), 0);
    chk(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
    chk(wr_bank_o == 1'b0, "R1", "bank in reset", int'(wr_bank_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R2: carrier high from reset, no low seen first -> ignored
    build(30, 1, 1'b1);
    send(0, 6, 0, 1'b0, 3);
    drain("R2");

    // R3: 00 and 01 dibits before the start dibit are not data
    build(30, 2, 1'b1); expect_frame("R3");
    send(3, 6, 0, 1'b0, 3);
    drain("R3");

    // R4: edge glitches around each dibit, only centre is sampled
    build(24, 3, 1'b1); expect_frame("R4");
    send(0, 5, 0, 1'b1, 3);
    drain("R4");

    // R5: trailing partial byte dropped
    build(25, 4, 1'b1); expect_frame("R5");
    send(0, 4, 3, 1'b0, 3);
    drain("R5");

    // R8: corrupted FCS
    build(40, 5, 1'b0); expect_frame("R8");
    send(0, 4, 0, 1'b0, 3);
    drain("R8");

    // R7: below minimum, exactly minimum, exactly maximum, over maximum
    build(12, 6, 1'b1); expect_frame("R7");
    send(0, 4, 0, 1'b0, 3);
    drain("R7");
    build(MIN_LEN, 7, 1'b1); expect_frame("R7");
    send(0, 4, 0, 1'b0, 3);
    drain("R7");
    build(MAX_LEN, 8, 1'b1); expect_frame("R7");
    send(0, 4, 0, 1'b0, 3);
    drain("R7");
    build(MAX_LEN + 4, 9, 1'b1); expect_frame("R7");
    send(0, 4, 0, 1'b0, 3);
    drain("R7");

    // R10: carrier drops mid preamble, then a normal frame keeps bank sequence
    crs_dv_i = 1'b1;
    for (int i = 0; i < 3; i++) dibit(2'b01, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) dibit(2'b00, 1'b0, 1'b0);
    drain("R10");
    build(22, 10, 1'b1); expect_frame("R10");
    send(0, 4, 0, 1'b0, 3);
    drain("R10");

    // R9: back-to-back frames separated by a single low dibit
    build(30, 11, 1'b1); expect_frame("R9");
    send(0, 4, 0, 1'b0, 1);
    build(28, 12, 1'b1); expect_frame("R9");
    send(0, 4, 0, 1'b0, 3);
    drain("R9");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule